// File: doc/BRIEF.md
# Bit-String Memory Operation Engine

This block applies a two-input logical function to a pair of bit strings stored in word-addressed memory and writes the outcome back into the destination string. Each string starts at any bit position inside a word and may span any number of words. The block therefore streams bits across word boundaries. It fetches a new source word only when the source bit index enters a new word. It reads, modifies and writes back each destination word. Destination bits outside the string keep their values.

A controller supplies five operands (destination bit offset, source bit offset, length in bits, destination word address, source word address) and a 3-bit function select, then pulses `start`. Only the low bits of each offset are used. The low address bits are cleared, so every access is word aligned. The engine processes one bit per cycle in the `STEP` state and walks upward from bit 0. Bit i of a string lies in word `(offset+i)/WORD_W` past its base, at bit position `(offset+i) mod WORD_W`, numbered from the LSB. When the engine completes, it presents updated operands (offsets, addresses, remaining length 0) that point just past the processed strings.

States: `IDLE` waits for `start`. `SRC_REQ`/`SRC_WAIT` issue a source read and wait for its data. `DST_REQ`/`DST_WAIT` do the same for the destination word. `STEP` combines one bit. `WB` writes the destination word back. `FIN` pulses `done`. The transitions are:
- `IDLE`→`FIN` on a zero-length start.
- `IDLE`→`SRC_REQ` on any other start.
- `SRC_REQ`→`SRC_WAIT` and `DST_REQ`→`DST_WAIT` on `mem_ready`.
- `SRC_WAIT`→`DST_REQ` when a destination word is still needed, otherwise `SRC_WAIT`→`STEP`. Both leave on `mem_rvalid`.
- `DST_WAIT`→`STEP` on `mem_rvalid`.
- `STEP`→`WB` on the last bit or the last bit of a destination word.
- `STEP`→`SRC_REQ` on the last bit of a source word.
- `WB`→`FIN`, `SRC_REQ`, `DST_REQ` or `STEP` on `mem_ready`, according to the remaining length and the words still needed.
- `FIN`→`IDLE`.

Top module: `bitstr_engine`

## Requirements
- R1: Only the low 5 bits of each offset input are used. Every memory address issued has its two low bits zero, because bits 1:0 of each address input are cleared.
- R2: Bit i of a string is read from or written to word `(off+i)>>5` past its aligned base, at bit `(off+i)&31`, for i from 0 up to length-1.
- R3: `op` selects the result from source bit s and destination bit d:
  - 0 gives s
  - 1 gives s|d
  - 2 gives s&d
  - 3 gives s^d
  - 4 gives ~s|d
  - 5 gives ~s&d
  - 6 gives ~s^d
  - 7 gives ~s
- R4: Destination bits outside the string, including the unused bits of its first and last word, keep their values.
- R5: Each destination word touched is written exactly once, after its last string bit has been processed. The written data equals the final content of that word.
- R6: Each source word and each destination word is read exactly once per operation.
- R7: A length of zero causes no memory request and raises `done` in the cycle after `start`.
- R8: Operands and `op` are captured on the `start` cycle. A `start` while `busy` is high is ignored.
- R9: `busy` rises in the cycle after an accepted `start`. `busy` stays high through the single-cycle `done` pulse and is low in the next cycle.
- R10: A request keeps `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ready`. No new request is made while a read awaits `mem_rvalid`.
- R11: After completion, each offset output equals `(off+len)&31`, each address output equals the aligned base plus `4*((off+len)>>5)`, and `len_o` is 0.
- R12: After reset, `busy`, `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle start pulse |
| op | input | 3 | Function select (R3 encoding) |
| dst_off_i | input | WORD_W | Destination bit offset |
| src_off_i | input | WORD_W | Source bit offset |
| len_i | input | LEN_W | Length in bits |
| dst_addr_i | input | ADDR_W | Destination byte address |
| src_addr_i | input | ADDR_W | Source byte address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| dst_off_o | output | OFF_W | Updated destination offset |
| src_off_o | output | OFF_W | Updated source offset |
| len_o | output | LEN_W | Remaining length |
| dst_addr_o | output | ADDR_W | Updated destination word address |
| src_addr_o | output | ADDR_W | Updated source word address |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Request byte address |
| mem_wdata | output | WORD_W | Write data |
| mem_ready | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | WORD_W | Read data |

## Verification
The bench builds the engine with its defaults of 32-bit words, addresses and lengths. This makes the 5-bit offset masking and the 2-bit address alignment the real ones. The test cases cover strings that straddle two to six words, a string that ends exactly on a word edge, lengths of one and zero, and offset and address inputs carrying junk upper or low bits. A memory model with a pseudo-random ready pattern and read latency checks every accepted write against a behavioural bit-loop result. This exposes wrong word crossings and extra or missing writes.

// File: rtl/bitstr_pkg.sv
package bitstr_pkg;

    typedef enum logic [2:0] {
        OP_COPY = 3'd0,
        OP_OR   = 3'd1,
        OP_AND  = 3'd2,
        OP_XOR  = 3'd3,
        OP_ORN  = 3'd4,
        OP_ANDN = 3'd5,
        OP_XORN = 3'd6,
        OP_INV  = 3'd7
    } bs_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SRC_REQ,
        S_SRC_WAIT,
        S_DST_REQ,
        S_DST_WAIT,
        S_STEP,
        S_WB,
        S_FIN
    } bs_state_e;

endpackage

// File: rtl/bitstr_combine.sv
module bitstr_combine
    import bitstr_pkg::*;
(
    input  bs_op_e op,
    input  logic   s_bit,
    input  logic   d_bit,
    output logic   r_bit
);
    always_comb begin
        unique case (op)
            OP_COPY: r_bit = s_bit;
            OP_OR:   r_bit = s_bit | d_bit;
            OP_AND:  r_bit = s_bit & d_bit;
            OP_XOR:  r_bit = s_bit ^ d_bit;
            OP_ORN:  r_bit = ~s_bit | d_bit;
            OP_ANDN: r_bit = ~s_bit & d_bit;
            OP_XORN: r_bit = ~s_bit ^ d_bit;
            OP_INV:  r_bit = ~s_bit;
            default: r_bit = s_bit;
        endcase
    end
endmodule

// File: rtl/bitstr_cursor.sv
module bitstr_cursor #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [OFF_W-1:0]  off_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              adv,
    output logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    localparam int ALIGN_W = $clog2(STEP);

    logic unused_low;
    assign unused_low = ^addr_in[ALIGN_W-1:0];
    assign at_last    = &off;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off  <= '0;
            addr <= '0;
        end else if (load) begin
            off  <= off_in;
            addr <= {addr_in[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
        end else if (adv) begin
            off <= off + 1'b1;
            if (at_last) addr <= addr + ADDR_W'(STEP);
        end
    end
endmodule

// File: rtl/bitstr_engine.sv
module bitstr_engine
    import bitstr_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 32,
    localparam int OFF_W = $clog2(WORD_W),
    localparam int BYTES = WORD_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [WORD_W-1:0] dst_off_i,
    input  logic [WORD_W-1:0] src_off_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [ADDR_W-1:0] dst_addr_i,
    input  logic [ADDR_W-1:0] src_addr_i,
    output logic              busy,
    output logic              done,
    output logic [OFF_W-1:0]  dst_off_o,
    output logic [OFF_W-1:0]  src_off_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [ADDR_W-1:0] dst_addr_o,
    output logic [ADDR_W-1:0] src_addr_o,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata
);
    bs_state_e         state, state_nx;
    bs_op_e            op_q;
    logic [LEN_W-1:0]  rem;
    logic [WORD_W-1:0] sbuf, dbuf;
    logic [ADDR_W-1:0] wb_addr;
    logic              need_src, need_dst;
    logic              accept, stepping, last_bit;
    logic              s_last, d_last, r_bit;
    logic [OFF_W-1:0]  s_off, d_off;
    logic [ADDR_W-1:0] s_addr, d_addr;
    logic              unused_hi;

    assign unused_hi = ^{dst_off_i[WORD_W-1:OFF_W], src_off_i[WORD_W-1:OFF_W]};
    assign accept    = start && (state == S_IDLE);
    assign stepping  = (state == S_STEP);
    assign last_bit  = (rem == LEN_W'(1));

    bitstr_cursor #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .STEP(BYTES)) u_src_cur (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .off_in(src_off_i[OFF_W-1:0]), .addr_in(src_addr_i),
        .adv(stepping), .off(s_off), .addr(s_addr), .at_last(s_last)
    );

    bitstr_cursor #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .STEP(BYTES)) u_dst_cur (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .off_in(dst_off_i[OFF_W-1:0]), .addr_in(dst_addr_i),
        .adv(stepping), .off(d_off), .addr(d_addr), .at_last(d_last)
    );

    bitstr_combine u_comb (
        .op(op_q), .s_bit(sbuf[s_off]), .d_bit(dbuf[d_off]), .r_bit(r_bit)
    );

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (start) state_nx = (len_i == '0) ? S_FIN : S_SRC_REQ;
            S_SRC_REQ:  if (mem_ready) state_nx = S_SRC_WAIT;
            S_SRC_WAIT: if (mem_rvalid) state_nx = need_dst ? S_DST_REQ : S_STEP;
            S_DST_REQ:  if (mem_ready) state_nx = S_DST_WAIT;
            S_DST_WAIT: if (mem_rvalid) state_nx = S_STEP;
            S_STEP: begin
                if (last_bit || d_last) state_nx = S_WB;
                else if (s_last)        state_nx = S_SRC_REQ;
            end
            S_WB: begin
                if (mem_ready) begin
                    if (rem == '0)    state_nx = S_FIN;
                    else if (need_src) state_nx = S_SRC_REQ;
                    else if (need_dst) state_nx = S_DST_REQ;
                    else               state_nx = S_STEP;
                end
            end
            S_FIN:   state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_COPY;
            rem      <= '0;
            sbuf     <= '0;
            dbuf     <= '0;
            wb_addr  <= '0;
            need_src <= 1'b0;
            need_dst <= 1'b0;
        end else begin
            if (accept) begin
                op_q     <= bs_op_e'(op);
                rem      <= len_i;
                need_src <= 1'b1;
                need_dst <= 1'b1;
            end
            if (state == S_SRC_WAIT && mem_rvalid) begin
                sbuf     <= mem_rdata;
                need_src <= 1'b0;
            end
            if (state == S_DST_WAIT && mem_rvalid) begin
                dbuf     <= mem_rdata;
                need_dst <= 1'b0;
            end
            if (stepping) begin
                dbuf[d_off] <= r_bit;
                rem         <= rem - 1'b1;
                wb_addr     <= d_addr;
                if (s_last) need_src <= 1'b1;
                if (d_last) need_dst <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (state != S_IDLE);
        done      = (state == S_FIN);
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            S_SRC_REQ: begin
                mem_req  = 1'b1;
                mem_addr = s_addr;
            end
            S_DST_REQ: begin
                mem_req  = 1'b1;
                mem_addr = d_addr;
            end
            S_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = wb_addr;
                mem_wdata = dbuf;
            end
            default: ;
        endcase
    end

    assign dst_off_o  = d_off;
    assign src_off_o  = s_off;
    assign dst_addr_o = d_addr;
    assign src_addr_o = s_addr;
    assign len_o      = rem;
endmodule

// File: rtl/bitstr_engine_chk.sv
module bitstr_engine_chk #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int LEN_W  = 32,
    parameter int BYTES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [LEN_W-1:0]  len_i,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic              mem_rvalid
);
    localparam int ALIGN_W = $clog2(BYTES);

    logic rd_pend;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               rd_pend <= 1'b0;
        else if (mem_req && !mem_we && mem_ready) rd_pend <= 1'b1;
        else if (mem_rvalid)                      rd_pend <= 1'b0;
    end

    // R1
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[ALIGN_W-1:0] == '0));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                     && (!mem_we || $stable(mem_wdata))));

    // R10
    one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pend |-> !mem_req);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R9
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R9
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R7
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && len_i == '0) |=> (done && !mem_req));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);
endmodule

bind bitstr_engine bitstr_engine_chk #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LEN_W(LEN_W), .BYTES(BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .len_i(len_i), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid)
);

// File: tb/bitstr_engine_bench.sv
module bitstr_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [31:0] dst_off_i = '0, src_off_i = '0, len_i = '0, dst_addr_i = '0, src_addr_i = '0;
    logic        busy, done;
    logic [4:0]  dst_off_o, src_off_o;
    logic [31:0] len_o, dst_addr_o, src_addr_o;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0, mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    bitstr_engine u_bitstr_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .dst_off_i(dst_off_i), .src_off_i(src_off_i), .len_i(len_i),
        .dst_addr_i(dst_addr_i), .src_addr_i(src_addr_i),
        .busy(busy), .done(done), .dst_off_o(dst_off_o), .src_off_o(src_off_o),
        .len_o(len_o), .dst_addr_o(dst_addr_o), .src_addr_o(src_addr_o),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    always #5 clk = ~clk;

    int checks = 0, errors = 0;
    bit finished = 0;

    logic [31:0] mem [64];
    logic [31:0] exp_mem [64];
    int rd_cnt = 0, wr_cnt = 0;
    int exp_lo = 0, exp_hi = -1;

    // memory responder state
    logic [15:0] lfsr = 16'hACE1;
    bit   hs_valid = 0, hs_we = 0;
    int   hs_idx = 0;
    logic [31:0] hs_data = '0;
    bit   rd_pending = 0;
    int   rd_idx = 0, rd_delay = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory model sampled and driven at the falling edge; compares writes each clock
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (hs_valid) begin
            if (hs_we) begin
                wr_cnt++;
                // R5: every accepted write must carry the final word, inside the string's words
                check(hs_idx >= exp_lo && hs_idx <= exp_hi, "R5", "write word index", hs_idx, exp_lo);
                check(hs_data == exp_mem[hs_idx], "R5", "write data", hs_data, exp_mem[hs_idx]);
                mem[hs_idx] = hs_data;
            end else begin
                rd_cnt++;
                rd_pending = 1;
                rd_idx = hs_idx;
                rd_delay = int'(lfsr[3:2]) % 3;
            end
        end
        mem_rvalid = 1'b0;
        if (rd_pending) begin
            if (rd_delay == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata = mem[rd_idx];
                rd_pending = 0;
            end else rd_delay--;
        end
        mem_ready = mem_req && (lfsr[1:0] != 2'b00);
        hs_valid = mem_req && mem_ready;
        hs_we = mem_we;
        hs_idx = int'(mem_addr[7:2]);
        hs_data = mem_wdata;
    end

    function automatic bit ref_fn(input int f, input bit s, input bit d);
        case (f)
            0: return s;
            1: return s | d;
            2: return s & d;
            3: return s ^ d;
            4: return !s | d;
            5: return !s & d;
            6: return !(s ^ d);
            default: return !s;
        endcase
    endfunction

    task automatic fill(input logic [31:0] seed);
        for (int k = 0; k < 64; k++) mem[k] = (k * 32'h9E37_79B1) ^ seed ^ {k[7:0], 24'h5A3C96};
    endtask

    task automatic run_op(input int f, input logic [31:0] doff_in, input logic [31:0] soff_in,
                          input logic [31:0] len, input logic [31:0] da, input logic [31:0] sa,
                          input bit inject, input string tag);
        int doff, soff, dbase, sbase, nd, ns, wait_cyc;
        doff = int'(doff_in[4:0]);
        soff = int'(soff_in[4:0]);
        dbase = int'(da[7:2]);
        sbase = int'(sa[7:2]);
        for (int k = 0; k < 64; k++) exp_mem[k] = mem[k];
        for (int i = 0; i < int'(len); i++) begin
            int sp, dp;
            bit s, d;
            sp = soff + i;
            dp = doff + i;
            s = mem[sbase + sp / 32][sp % 32];
            d = mem[dbase + dp / 32][dp % 32];
            exp_mem[dbase + dp / 32][dp % 32] = ref_fn(f, s, d);
        end
        nd = (len == 0) ? 0 : (doff + int'(len) - 1) / 32 + 1;
        ns = (len == 0) ? 0 : (soff + int'(len) - 1) / 32 + 1;
        exp_lo = dbase;
        exp_hi = dbase + nd - 1;
        rd_cnt = 0;
        wr_cnt = 0;

        @(negedge clk);
        op = 3'(f); dst_off_i = doff_in; src_off_i = soff_in; len_i = len;
        dst_addr_i = da; src_addr_i = sa; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R8: scramble the operand inputs after the start cycle
        op = 3'(f + 3); len_i = 32'd7; dst_off_i = 32'd9; src_off_i = 32'd2;
        dst_addr_i = 32'h0000_00F0; src_addr_i = 32'h0000_0010;
        check(busy == 1'b1, "R9", {tag, " busy after start"}, 32'(busy), 32'd1);
        if (len == 0) check(done == 1'b1, "R7", {tag, " done next cycle"}, 32'(done), 32'd1);
        if (inject) begin
            repeat (4) @(negedge clk);
            // R8: start while busy is ignored
            start = 1'b1; op = 3'd7; len_i = 32'd3;
            @(negedge clk);
            start = 1'b0;
        end
        wait_cyc = 0;
        while (!done && wait_cyc < 5000) begin
            @(negedge clk);
            wait_cyc++;
        end
        check(done == 1'b1, "R9", {tag, " done seen"}, 32'(done), 32'd1);
        check(busy == 1'b1, "R9", {tag, " busy during done"}, 32'(busy), 32'd1);
        @(negedge clk);
        check(!busy && !done, "R9", {tag, " idle after done"}, {30'd0, busy, done}, 32'd0);
        // R2 R3 R4: full memory image against the bit-loop result
        for (int k = 0; k < 64; k++)
            check(mem[k] == exp_mem[k], "R2/R3/R4", $sformatf("%s word %0d", tag, k), mem[k], exp_mem[k]);
        // R6
        check(rd_cnt == ns + nd, "R6", {tag, " read count"}, rd_cnt, ns + nd);
        // R5 / R7
        check(wr_cnt == nd, (len == 0) ? "R7" : "R5", {tag, " write count"}, wr_cnt, nd);
        // R11
        check(dst_off_o == 5'((doff + int'(len)) % 32), "R11", {tag, " dst offset"}, dst_off_o, 5'((doff + int'(len)) % 32));
        check(src_off_o == 5'((soff + int'(len)) % 32), "R11", {tag, " src offset"}, src_off_o, 5'((soff + int'(len)) % 32));
        check(dst_addr_o == {da[31:2], 2'b00} + 32'(4 * ((doff + int'(len)) / 32)), "R11", {tag, " dst addr"},
              dst_addr_o, {da[31:2], 2'b00} + 32'(4 * ((doff + int'(len)) / 32)));
        check(src_addr_o == {sa[31:2], 2'b00} + 32'(4 * ((soff + int'(len)) / 32)), "R11", {tag, " src addr"},
              src_addr_o, {sa[31:2], 2'b00} + 32'(4 * ((soff + int'(len)) / 32)));
        check(len_o == 32'd0, "R11", {tag, " len"}, len_o, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12
        check(!busy && !done && !mem_req, "R12", "reset outputs", {29'd0, busy, done, mem_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mem_req, "R12", "idle after reset", {30'd0, busy, mem_req}, 32'd0);

        fill(32'h1111_0000); run_op(0, 0, 0, 32, 32'h80, 32'h00, 0, "R2 copy aligned");
        fill(32'h2222_0000); run_op(1, 3, 29, 70, 32'h84, 32'h04, 0, "R3 or");
        fill(32'h3333_0000); run_op(2, 30, 7, 40, 32'h88, 32'h08, 0, "R3 and");
        fill(32'h4444_0000); run_op(3, 32'hFFFF_FFE3, 32'h25, 50, 32'h83, 32'h0B, 0, "R1 xor masked");
        for (int f = 4; f < 8; f++) begin
            fill(32'h5555_0000 + 32'(f));
            run_op(f, 32'(f * 5), 32'(31 - f), 32'(33 + f * 9), 32'h90, 32'h10, 0,
                   $sformatf("R3 op%0d", f));
        end
        fill(32'h6666_0000); run_op(3, 17, 4, 0, 32'hA0, 32'h20, 0, "R7 zero length");
        fill(32'h7777_0000); run_op(0, 10, 20, 22, 32'hA4, 32'h24, 0, "R4 word-end");
        fill(32'h8888_0000); run_op(5, 31, 31, 1, 32'hA8, 32'h28, 0, "R4 single bit");
        fill(32'h9999_0000); run_op(1, 13, 2, 150, 32'hB0, 32'h30, 1, "R8 busy start");

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule